// File: doc/BRIEF.md
# Asynchronous Static Memory Sequencer

This block sits between a clocked host and an asynchronous 16-bit static memory. The host issues one word at a time: an address, a read/write flag, write data and a per-byte mask. The block turns each request into a pin sequence with four phases: deselected idle, select, strobe or access, and hold. Each phase lasts a whole number of clock cycles. The counts are computed at elaboration from nanosecond minimums and the clock period in picoseconds, by ceiling division, and no count is below one. Read data comes back with a one-cycle valid pulse.

A per-request mode keeps the memory's output enable LOW during a write. In that mode the block waits out the memory's output turn-off time before it drives the data bus. It also lengthens the write strobe so that the full data setup time still fits inside the strobe. A request whose byte mask is all zero completes at once, and no memory pin changes. Between requests the memory sits in low-power standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and whenever no transfer is in progress, the pins are in standby: `mem_sel_n`=1, `mem_sel_p`=0, `mem_wr_n`=1, `mem_rd_n`=1, `mem_lane_n`=2'b11 and `mem_dout_en`=0.
- R2: `req_ready` is high only while idle. After a request with a non-zero mask is accepted, `req_ready` stays low for exactly 12 cycles for a normal write, 13 for a read and 14 for a write in output-enable-low mode. These figures assume the default 4000 ps clock.
- R3: The write strobe `mem_wr_n` stays LOW for at least ceil(35 ns / clock) cycles. At defaults this is exactly 9 cycles for a normal write and 12 in output-enable-low mode.
- R4: `mem_dout_en` is high only while `mem_wr_n` is LOW. For a normal write, data is driven for every strobe cycle, 9 cycles at defaults, which covers the 25 ns setup. Driving stops at the edge that raises the strobe.
- R5: With `wr_rdlow_mode`=1 at acceptance, `mem_rd_n` is LOW for the whole selected period of the write. The data bus stays undriven for the first ceil(18 ns / clock) strobe cycles, 5 at defaults, and is then driven for ceil(25 ns / clock) cycles, 7 at defaults, up to the strobe's rise.
- R6: A read holds `mem_rd_n` LOW for the whole selected period. It samples `mem_din` at least ceil(45 ns / clock) cycles after the address and select become valid. It then returns the word on `rsp_rdata` with `rsp_valid` high for one cycle.
- R7: Mask bit 0 enables the low lane (`mem_lane_n[0]`, data bits 7:0) and mask bit 1 enables the high lane (`mem_lane_n[1]`, bits 15:8). Lane enables are active-low. A write changes only the enabled lanes. A read returns zero in the disabled lanes.
- R8: A request with mask 2'b00 never selects the memory. A read with this mask returns `rsp_valid` with data 0 in the cycle after acceptance.
- R9: Each transfer keeps the memory selected for at least ceil(45 ns / clock) cycles, which is 12 at defaults.
- R10: `mem_addr` holds steady for the whole time the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Active-high byte mask |
| wr_rdlow_mode | input | 1 | Write with memory output enable held LOW |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read data, zero in disabled lanes |
| mem_addr | output | ADDR_W | Memory address |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel_p | output | 1 | Active-high memory select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low memory output enable |
| mem_lane_n | output | DATA_W/8 | Active-low byte lane enables |
| mem_dout | output | DATA_W | Data toward memory |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DATA_W | Data from memory |

## Verification
The bench measures the strobe length, the offset and length of data driving inside the strobe, and the selected span of every transfer. A design that left out the stretched strobe or the drive delay in output-enable-low mode would show a 9-cycle strobe, or data driven from the first strobe cycle. The bench also writes single lanes and reads them back through a memory model that returns filler bytes on disabled lanes. A design that swapped the lanes, or leaked filler into the response, would return wrong words. Zero-mask requests check that no select pulse appears and that the zero response arrives the next cycle.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Ceiling of a nanosecond minimum over the clock period, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_len - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == '0);

    // A phase of zero cycles would break every minimum (R9).
    p_len_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_len != '0));

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane (
    input  logic       sel,
    input  logic       en,
    input  logic [7:0] wbyte,
    input  logic [7:0] din,
    output logic       lane_n,
    output logic [7:0] dout,
    output logic [7:0] rbyte
);
    assign lane_n = !(sel && en);
    assign dout   = wbyte;
    assign rbyte  = en ? din : 8'h00;
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int CLK_PS     = 4000,
    parameter int T_CYC_NS   = 45,
    parameter int T_ADV_NS   = 45,
    parameter int T_OEV_NS   = 22,
    parameter int T_WPL_NS   = 35,
    parameter int T_ASU_NS   = 35,
    parameter int T_DSU_NS   = 25,
    parameter int T_WOFF_NS  = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_mask,
    input  logic                   wr_rdlow_mode,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   mem_sel_n,
    output logic                   mem_sel_p,
    output logic                   mem_wr_n,
    output logic                   mem_rd_n,
    output logic [DATA_W/8-1:0]    mem_lane_n,
    output logic [DATA_W-1:0]      mem_dout,
    output logic                   mem_dout_en,
    input  logic [DATA_W-1:0]      mem_din
);
    localparam int LANES  = DATA_W / 8;
    localparam int N_CYC  = ns_to_cyc(T_CYC_NS, CLK_PS);
    localparam int N_ADV  = ns_to_cyc(T_ADV_NS, CLK_PS);
    localparam int N_OEV  = ns_to_cyc(T_OEV_NS, CLK_PS);
    localparam int N_WPL  = ns_to_cyc(T_WPL_NS, CLK_PS);
    localparam int N_ASU  = ns_to_cyc(T_ASU_NS, CLK_PS);
    localparam int N_DSU  = ns_to_cyc(T_DSU_NS, CLK_PS);
    localparam int N_WOFF = ns_to_cyc(T_WOFF_NS, CLK_PS);

    localparam int SETUP_LEN  = 1;
    // Address is already valid for the one setup cycle before the strobe falls.
    localparam int WR_LEN     = imax(imax(N_WPL, N_DSU), imax(N_ASU - SETUP_LEN, 1));
    localparam int WR_OE_LEN  = imax(WR_LEN, N_WOFF + N_DSU);
    localparam int RD_LEN     = imax(imax(N_ADV, N_OEV) - SETUP_LEN, 1);
    localparam int WR_HOLD    = imax(N_CYC - SETUP_LEN - WR_LEN, 1);
    localparam int WR_OE_HOLD = imax(N_CYC - SETUP_LEN - WR_OE_LEN, 1);
    localparam int RD_HOLD    = imax(N_CYC - SETUP_LEN - RD_LEN, 1);
    localparam int MAX_LEN    = imax(imax(WR_OE_LEN, RD_LEN), imax(imax(WR_HOLD, RD_HOLD), WR_LEN));
    localparam int CNT_W      = $clog2(MAX_LEN + 1);
    localparam int DRV_FROM   = WR_OE_LEN - N_WOFF;

    typedef struct packed {
        phase_e             ph;
        logic               wr;
        logic               rdlow;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [LANES-1:0]   mask;
        logic [DATA_W-1:0]  rdata;
        logic               rvalid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_last;
    logic             sel;
    logic [DATA_W-1:0] lane_rd;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_len (tmr_len),
        .cnt      (tmr_cnt),
        .last     (tmr_last)
    );

    assign sel = (ctl_q.ph != PH_IDLE);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sram_byte_lane u_lane (
            .sel    (sel),
            .en     (ctl_q.mask[i]),
            .wbyte  (ctl_q.wdata[8*i +: 8]),
            .din    (mem_din[8*i +: 8]),
            .lane_n (mem_lane_n[i]),
            .dout   (mem_dout[8*i +: 8]),
            .rbyte  (lane_rd[8*i +: 8])
        );
    end

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        tmr_load     = 1'b0;
        tmr_len      = '0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    if (req_mask == '0) begin
                        ctl_d.rvalid = !req_write;
                        ctl_d.rdata  = '0;
                    end else begin
                        ctl_d.ph    = PH_SETUP;
                        ctl_d.wr    = req_write;
                        ctl_d.rdlow = req_write && wr_rdlow_mode;
                        ctl_d.addr  = req_addr;
                        ctl_d.wdata = req_wdata;
                        ctl_d.mask  = req_mask;
                        tmr_load    = 1'b1;
                        tmr_len     = CNT_W'(SETUP_LEN);
                    end
                end
            end
            PH_SETUP: begin
                if (tmr_last) begin
                    ctl_d.ph = PH_ACCESS;
                    tmr_load = 1'b1;
                    if (!ctl_q.wr)      tmr_len = CNT_W'(RD_LEN);
                    else if (ctl_q.rdlow) tmr_len = CNT_W'(WR_OE_LEN);
                    else                tmr_len = CNT_W'(WR_LEN);
                end
            end
            PH_ACCESS: begin
                if (tmr_last) begin
                    ctl_d.ph = PH_HOLD;
                    tmr_load = 1'b1;
                    if (!ctl_q.wr) begin
                        tmr_len      = CNT_W'(RD_HOLD);
                        ctl_d.rdata  = lane_rd;
                        ctl_d.rvalid = 1'b1;
                    end else if (ctl_q.rdlow) begin
                        tmr_len = CNT_W'(WR_OE_HOLD);
                    end else begin
                        tmr_len = CNT_W'(WR_HOLD);
                    end
                end
            end
            PH_HOLD: begin
                if (tmr_last) ctl_d.ph = PH_IDLE;
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.ph    <= PH_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.ph == PH_IDLE);
    assign rsp_valid   = ctl_q.rvalid;
    assign rsp_rdata   = ctl_q.rdata;
    assign mem_addr    = ctl_q.addr;
    assign mem_sel_n   = !sel;
    assign mem_sel_p   = sel;
    assign mem_wr_n    = !(ctl_q.wr && ctl_q.ph == PH_ACCESS);
    assign mem_rd_n    = !(sel && (!ctl_q.wr || ctl_q.rdlow));
    assign mem_dout_en = ctl_q.wr && (ctl_q.ph == PH_ACCESS) &&
                         (!ctl_q.rdlow || tmr_cnt < CNT_W'(DRV_FROM));

    // ---------------- assertions ----------------
    logic [15:0] chk_wr_run, chk_drv_run, chk_sel_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_wr_run  <= '0;
            chk_drv_run <= '0;
            chk_sel_run <= '0;
        end else begin
            chk_wr_run  <= !mem_wr_n   ? chk_wr_run + 16'd1  : 16'd0;
            chk_drv_run <= !mem_wr_n   ? chk_drv_run + (mem_dout_en ? 16'd1 : 16'd0) : 16'd0;
            chk_sel_run <= !mem_sel_n  ? chk_sel_run + 16'd1 : 16'd0;
        end
    end

    p_standby_when_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel_p && mem_wr_n && !mem_dout_en));

    p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (chk_wr_run >= 16'(N_WPL)));

    p_drive_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> !mem_wr_n);

    p_data_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (chk_drv_run >= 16'(N_DSU)));

    p_turnaround_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dout_en && !mem_rd_n) |-> (chk_wr_run >= 16'(N_WOFF)));

    p_cycle_time_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sel_n) |-> (chk_sel_run >= 16'(N_CYC)));

    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr));

    p_lane_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel_n |-> (mem_lane_n != '1));

endmodule

// File: tb/tb_sram_seq_ctrl.sv
module tb_sram_seq_ctrl;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int LN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, wr_rdlow_mode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [LN-1:0] req_mask = '0;
    logic req_ready, rsp_valid, mem_sel_n, mem_sel_p, mem_wr_n, mem_rd_n, mem_dout_en;
    logic [DW-1:0] rsp_rdata, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;
    logic [LN-1:0] mem_lane_n;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sram_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .wr_rdlow_mode(wr_rdlow_mode), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_sel_p(mem_sel_p), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
        .mem_lane_n(mem_lane_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    // memory model: disabled lanes return filler 8'hA5
    logic [DW-1:0] mem [0:255];
    logic [DW-1:0] shadow [0:255];
    wire msel = !mem_sel_n && mem_sel_p;

    always_comb begin
        for (int i = 0; i < LN; i++)
            mem_din[8*i +: 8] = (msel && !mem_rd_n && mem_wr_n && !mem_lane_n[i])
                                ? mem[mem_addr[7:0]][8*i +: 8] : 8'hA5;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pin monitor
    int wr_cnt = 0, drv_cnt = 0, first_drv = -1, sel_cnt = 0, oe_hi = 0;
    int last_wr = 0, last_drv = 0, last_first = -1, last_sel = 0, last_oe_hi = 0;
    int sel_events = 0, viol_drv = 0, viol_addr = 0, viol_rdy = 0;
    bit prev_wr_low = 0, prev_sel = 0, pend_ok = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] pend = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dout_en && mem_wr_n) viol_drv++;
            if (!mem_wr_n) begin
                if (mem_dout_en && first_drv < 0) first_drv = wr_cnt;
                wr_cnt++;
                if (mem_dout_en) begin drv_cnt++; pend = mem_dout; pend_ok = 1; end
            end else if (prev_wr_low) begin
                last_wr = wr_cnt; last_drv = drv_cnt; last_first = first_drv;
                wr_cnt = 0; drv_cnt = 0; first_drv = -1;
                if (pend_ok && msel)
                    for (int i = 0; i < LN; i++)
                        if (!mem_lane_n[i]) mem[mem_addr[7:0]][8*i +: 8] = pend[8*i +: 8];
                pend_ok = 0;
            end
            if (msel) begin
                sel_cnt++;
                if (prev_sel && mem_addr != prev_addr) viol_addr++;
                if (mem_rd_n) oe_hi++;
                if (req_ready) viol_rdy++;
            end else if (prev_sel) begin
                last_sel = sel_cnt; last_oe_hi = oe_hi; sel_events++;
                sel_cnt = 0; oe_hi = 0;
            end
            prev_wr_low = !mem_wr_n;
            prev_sel = msel;
            prev_addr = mem_addr;
        end
    end

    // scoreboard
    logic [DW-1:0] expq [$];
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) chk("R6 unexpected response", 1, 0);
            else chk("R6/R7/R8 read data", int'(rsp_rdata), int'(expq.pop_front()));
        end
    end

    function automatic logic [DW-1:0] masked(input logic [DW-1:0] w, input logic [LN-1:0] m);
        logic [DW-1:0] r;
        for (int i = 0; i < LN; i++) r[8*i +: 8] = m[i] ? w[8*i +: 8] : 8'h00;
        return r;
    endfunction

    task automatic xfer(input bit w, input int a, input logic [DW-1:0] d,
                        input logic [LN-1:0] m, input bit oe);
        int busy;
        int ev0;
        ev0 = sel_events;
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = AW'(a); req_wdata = d;
        req_mask = m; wr_rdlow_mode = oe;
        if (!w) expq.push_back(masked(shadow[a], m));
        @(posedge clk);
        #1 req_valid = 0;
        busy = 0;
        forever begin
            @(negedge clk);
            if (req_ready) break;
            busy++;
        end
        #1;
        if (w)
            for (int i = 0; i < LN; i++) if (m[i]) shadow[a][8*i +: 8] = d[8*i +: 8];
        if (m == '0) begin
            chk("R8 busy cycles", busy, 0);
            chk("R8 no select pulse", sel_events, ev0);
        end else if (w) begin
            chk("R2 write busy", busy, oe ? 14 : 12);
            chk("R3 strobe length", last_wr, oe ? 12 : 9);
            chk("R9 selected span", last_sel, oe ? 14 : 12);
            if (oe) begin
                chk("R5 drive offset", last_first, 5);
                chk("R5 drive length", last_drv, 7);
                chk("R5 output enable low", last_oe_hi, 0);
            end else begin
                chk("R4 drive length", last_drv, 9);
                chk("R4 drive offset", last_first, 0);
            end
        end else begin
            chk("R2 read busy", busy, 13);
            chk("R6 output enable low", last_oe_hi, 0);
            chk("R9 read span", last_sel, 13);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 sel_n reset", int'(mem_sel_n), 1);
        chk("R1 sel_p reset", int'(mem_sel_p), 0);
        chk("R1 wr_n reset", int'(mem_wr_n), 1);
        chk("R1 rd_n reset", int'(mem_rd_n), 1);
        chk("R1 lanes reset", int'(mem_lane_n), 3);
        chk("R1 dout_en reset", int'(mem_dout_en), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R2 ready after reset", int'(req_ready), 1);

        xfer(1, 5, 16'h1234, 2'b11, 0);
        xfer(0, 5, 16'h0, 2'b11, 0);
        // R7 lane mapping
        xfer(1, 5, 16'hABCD, 2'b01, 0);
        xfer(0, 5, 16'h0, 2'b11, 0);
        xfer(1, 5, 16'h5566, 2'b10, 0);
        xfer(0, 5, 16'h0, 2'b01, 0);
        xfer(0, 5, 16'h0, 2'b10, 0);
        // R5 output-enable-low writes
        xfer(1, 9, 16'hBEEF, 2'b11, 1);
        xfer(0, 9, 16'h0, 2'b11, 0);
        xfer(1, 9, 16'h7700, 2'b10, 1);
        xfer(0, 9, 16'h0, 2'b11, 0);
        // R8 zero mask
        xfer(1, 5, 16'hFFFF, 2'b00, 0);
        xfer(0, 5, 16'h0, 2'b11, 0);
        xfer(0, 5, 16'h0, 2'b00, 0);
        // patterns
        for (int k = 0; k < 8; k++)
            xfer(1, 16 + k, 16'((k * 16'h1111) ^ 16'h0F0F), 2'(k % 3 + 1), k[0]);
        for (int k = 0; k < 8; k++)
            xfer(0, 16 + k, 16'h0, 2'b11, 0);
        repeat (4) @(negedge clk);
        chk("R4 drive outside strobe", viol_drv, 0);
        chk("R10 address changes while selected", viol_addr, 0);
        chk("R2 ready while selected", viol_rdy, 0);
        chk("R6 responses outstanding", expq.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule